// File: doc/BRIEF.md
# CAN Error Counter and Status Flags

This block keeps the receive and transmit error counts of a CAN controller and turns them into status flags and one error interrupt request. The protocol engine drives single-cycle strobes: a receive error, a successful receive, three separate transmit error classes (acknowledge, form, bit), a successful transmit, an invalid-message event and one overrun strobe per receive buffer.

Each counter is eight bits wide and saturates at 0 and 255. The two directions use different threshold rules. The receive warning asserts when the count has reached its level. The transmit warning asserts only when the count is above its level. The receive error-passive flag asserts above 127. These conditions, together with the invalid-message and overrun events, latch into sticky status bits. Software clears a sticky bit by writing a one to its position. The OR of all status bits is the summary error flag. The interrupt line is the summary flag gated by an enable input.

Top module: `can_err_track`

## Requirements
- R1: `rx_cnt_o` rises by one for each `rx_err_i` pulse and falls by one for each `rx_ok_i` pulse. When both pulse in the same cycle the count is unchanged. The count saturates at 0 and 255, and the new value is visible after the clock edge that samples the strobe.
- R2: `tx_cnt_o` rises by the number of transmit error strobes (`tx_ack_err_i`, `tx_form_err_i`, `tx_bit_err_i`) asserted in the cycle, adding one for each. It falls by one on `tx_ok_i` and saturates at 0 and 255.
- R3: `rx_warn_o` is high exactly while `rx_cnt_o` is 96 or more.
- R4: `rx_passive_o` is high exactly while `rx_cnt_o` is 128 or more, that is above 127.
- R5: `tx_warn_o` is high exactly while `tx_cnt_o` is 97 or more, that is above 96. A value of exactly 96 does not assert it.
- R6: Status bit layout of `stat_o`: bit 0 receive warning, bit 1 transmit warning, bit 2 receive error-passive, bit 3 invalid message, bit 4+b overrun of receive buffer b. Bits 0 to 2 set on the clock edge after the matching flag is seen high. Bit 3 and the overrun bits set on the edge that samples their strobe.
- R7: A status bit stays set until a one is written to its position on `clr_i`. If a set condition and a clear hit the same bit in the same cycle, the bit stays set.
- R8: `err_sum_o` is the OR of all `stat_o` bits. Transmit error strobes raise no status bit on their own while `tx_cnt_o` stays at 96 or below.
- R9: `irq_o` equals `err_sum_o` AND `err_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_err_i | input | 1 | Receive error strobe |
| rx_ok_i | input | 1 | Successful receive strobe |
| tx_ack_err_i | input | 1 | Transmit acknowledge error strobe |
| tx_form_err_i | input | 1 | Transmit form error strobe |
| tx_bit_err_i | input | 1 | Transmit bit error strobe |
| tx_ok_i | input | 1 | Successful transmit strobe |
| rx_bad_msg_i | input | 1 | Error seen during the last received message |
| rx_ovr_i | input | NBUF | Per-buffer receive overrun strobes |
| clr_i | input | 4+NBUF | Write-one-to-clear for the status bits |
| err_ie_i | input | 1 | Error interrupt enable |
| rx_cnt_o | output | 8 | Receive error count |
| tx_cnt_o | output | 8 | Transmit error count |
| rx_warn_o | output | 1 | Receive warning level reached |
| tx_warn_o | output | 1 | Transmit warning level exceeded |
| rx_passive_o | output | 1 | Receive error-passive |
| stat_o | output | 4+NBUF | Sticky status bits |
| err_sum_o | output | 1 | Summary error flag |
| irq_o | output | 1 | Error interrupt request |

## Verification
The counters and the three level flags show a strobe's effect after the first clock edge that samples it. The event status bits (invalid message, overrun) latch on that same edge. The level-driven status bits latch one edge later, because they sample the registered flags. The summary flag and the interrupt follow the status bits with no further delay. The bench drives each stimulus on a falling edge and compares every output against its arithmetic model on the next falling edge, so each result is read once the edge that produced it has passed. The model derives its level-driven status bits from its own pre-edge counter values, which keeps the one-edge lag.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  parameter int CNT_W = 8;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  typedef logic [CNT_W-1:0] cnt_t;

  // fixed positions of the condition and event status bits
  localparam int ST_RX_WARN = 0;
  localparam int ST_TX_WARN = 1;
  localparam int ST_RX_PASS = 2;
  localparam int ST_BAD_MSG = 3;
  localparam int ST_OVR0    = 4;

  // saturating add-then-subtract on an error count
  function automatic cnt_t sat_step(input cnt_t cur, input logic [1:0] up,
                                    input logic down);
    int t;
    t = int'(cur) + int'(up) - int'(down);
    if (t < 0) t = 0;
    if (t > CNT_MAX) t = CNT_MAX;
    return cnt_t'(t);
  endfunction

  // number of error classes flagged in one cycle
  function automatic logic [1:0] ones3(input logic a, input logic b, input logic c);
    return {1'b0, a} + {1'b0, b} + {1'b0, c};
  endfunction
endpackage

// File: rtl/err_counter.sv
module err_counter
  import can_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] up,
  input  logic       down,
  output cnt_t       cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= sat_step(cnt, up, down);
  end
endmodule

// File: rtl/level_cmp.sv
module level_cmp
  import can_err_pkg::*;
#(
  parameter int LVL    = 96,
  parameter bit STRICT = 1'b0
) (
  input  cnt_t cnt,
  output logic hit
);
  localparam cnt_t LVL_C = cnt_t'(LVL);
  generate
    if (STRICT) begin : g_above
      assign hit = (cnt > LVL_C);
    end else begin : g_reached
      assign hit = (cnt >= LVL_C);
    end
  endgenerate
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)      q[i] <= 1'b0;
        else if (set[i]) q[i] <= 1'b1;
        else if (clr[i]) q[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/can_err_track.sv
module can_err_track
  import can_err_pkg::*;
#(
  parameter int NBUF       = 2,
  parameter int RX_WARN_AT = 96,
  parameter int RX_PASS_GT = 127,
  parameter int TX_WARN_GT = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_err_i,
  input  logic              rx_ok_i,
  input  logic              tx_ack_err_i,
  input  logic              tx_form_err_i,
  input  logic              tx_bit_err_i,
  input  logic              tx_ok_i,
  input  logic              rx_bad_msg_i,
  input  logic [NBUF-1:0]   rx_ovr_i,
  input  logic [4+NBUF-1:0] clr_i,
  input  logic              err_ie_i,
  output logic [7:0]        rx_cnt_o,
  output logic [7:0]        tx_cnt_o,
  output logic              rx_warn_o,
  output logic              tx_warn_o,
  output logic              rx_passive_o,
  output logic [4+NBUF-1:0] stat_o,
  output logic              err_sum_o,
  output logic              irq_o
);
  localparam int ST_W = ST_OVR0 + NBUF;

  // named internal events, visible to the checker
  logic [1:0]      rx_up;
  logic [1:0]      tx_up;
  logic [ST_W-1:0] st_set;
  cnt_t            rx_cnt, tx_cnt;

  assign rx_up = {1'b0, rx_err_i};
  assign tx_up = ones3(tx_ack_err_i, tx_form_err_i, tx_bit_err_i);

  err_counter u_rx_cnt (.clk(clk), .rst_n(rst_n), .up(rx_up), .down(rx_ok_i), .cnt(rx_cnt));
  err_counter u_tx_cnt (.clk(clk), .rst_n(rst_n), .up(tx_up), .down(tx_ok_i), .cnt(tx_cnt));

  level_cmp #(.LVL(RX_WARN_AT), .STRICT(1'b0)) u_rx_warn (.cnt(rx_cnt), .hit(rx_warn_o));
  level_cmp #(.LVL(RX_PASS_GT), .STRICT(1'b1)) u_rx_pass (.cnt(rx_cnt), .hit(rx_passive_o));
  level_cmp #(.LVL(TX_WARN_GT), .STRICT(1'b1)) u_tx_warn (.cnt(tx_cnt), .hit(tx_warn_o));

  always_comb begin
    st_set             = '0;
    st_set[ST_RX_WARN] = rx_warn_o;
    st_set[ST_TX_WARN] = tx_warn_o;
    st_set[ST_RX_PASS] = rx_passive_o;
    st_set[ST_BAD_MSG] = rx_bad_msg_i;
  end
  generate
    for (genvar b = 0; b < NBUF; b++) begin : g_ovr
      // per-buffer overrun strobes land at their own positions
      logic ovr_ev;
      assign ovr_ev = rx_ovr_i[b];
    end
  endgenerate

  logic [ST_W-1:0] st_set_all;
  always_comb begin
    st_set_all = st_set;
    st_set_all[ST_W-1:ST_OVR0] = rx_ovr_i;
  end

  sticky_bank #(.N(ST_W)) u_stat (.clk(clk), .rst_n(rst_n), .set(st_set_all),
                                  .clr(clr_i), .q(stat_o));

  assign rx_cnt_o  = rx_cnt;
  assign tx_cnt_o  = tx_cnt;
  assign err_sum_o = |stat_o;
  assign irq_o     = err_sum_o & err_ie_i;
endmodule

// File: rtl/can_err_track_chk.sv
module can_err_track_chk #(
  parameter int NBUF = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_err_i,
  input logic              rx_ok_i,
  input logic              tx_ok_i,
  input logic [1:0]        tx_up,
  input logic              rx_bad_msg_i,
  input logic [4+NBUF-1:0] clr_i,
  input logic              err_ie_i,
  input logic [7:0]        rx_cnt_o,
  input logic [7:0]        tx_cnt_o,
  input logic              rx_warn_o,
  input logic              tx_warn_o,
  input logic              rx_passive_o,
  input logic [4+NBUF-1:0] stat_o,
  input logic              irq_o
);
  // R1
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_i == rx_ok_i) |=> $stable(rx_cnt_o));
  // R1
  rx_sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt_o == 8'hFF && !rx_ok_i) |=> (rx_cnt_o == 8'hFF));
  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_up == 2'd0 && !tx_ok_i) |=> $stable(tx_cnt_o));
  // R2
  tx_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt_o == 8'h00 && tx_up == 2'd0) |=> (tx_cnt_o == 8'h00));
  // R4
  pass_implies_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_passive_o |-> rx_warn_o);
  // R5
  tx_warn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_warn_o |-> (tx_cnt_o > 8'd96));
  // R6
  bad_msg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bad_msg_i |=> stat_o[3]);
  // R7
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_o) & ~$past(clr_i)) & ~stat_o) == '0));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_ie_i |-> !irq_o);
endmodule

bind can_err_track can_err_track_chk #(.NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_err_i(rx_err_i), .rx_ok_i(rx_ok_i),
  .tx_ok_i(tx_ok_i), .tx_up(tx_up), .rx_bad_msg_i(rx_bad_msg_i),
  .clr_i(clr_i), .err_ie_i(err_ie_i), .rx_cnt_o(rx_cnt_o), .tx_cnt_o(tx_cnt_o),
  .rx_warn_o(rx_warn_o), .tx_warn_o(tx_warn_o), .rx_passive_o(rx_passive_o),
  .stat_o(stat_o), .irq_o(irq_o));

// File: tb/tb_can_err_track.sv
`timescale 1ns/1ps
module tb_can_err_track;
  localparam int NB = 2;
  localparam int SW = 4 + NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_err, rx_ok, ta, tf, tb, tok, bad, ie;
  logic [NB-1:0] ovr;
  logic [SW-1:0] clr;
  logic [7:0] rx_cnt, tx_cnt;
  logic rx_warn, tx_warn, rx_pass, esum, irq;
  logic [SW-1:0] stat;

  int nchk = 0, nfail = 0;
  int m_rx = 0, m_tx = 0;
  logic [SW-1:0] m_st = '0;

  always #10 clk = ~clk;  // 50 MHz

  can_err_track #(.NBUF(NB)) dut (
    .clk(clk), .rst_n(rst_n), .rx_err_i(rx_err), .rx_ok_i(rx_ok),
    .tx_ack_err_i(ta), .tx_form_err_i(tf), .tx_bit_err_i(tb), .tx_ok_i(tok),
    .rx_bad_msg_i(bad), .rx_ovr_i(ovr), .clr_i(clr), .err_ie_i(ie),
    .rx_cnt_o(rx_cnt), .tx_cnt_o(tx_cnt), .rx_warn_o(rx_warn), .tx_warn_o(tx_warn),
    .rx_passive_o(rx_pass), .stat_o(stat), .err_sum_o(esum), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clamp(input int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  task automatic compare_all();
    logic [SW-1:0] st = m_st;
    chk(rx_cnt == m_rx, "R1 rx count", rx_cnt, m_rx);
    chk(tx_cnt == m_tx, "R2 tx count", tx_cnt, m_tx);
    chk(rx_warn == (m_rx >= 96), "R3 rx warning", rx_warn, m_rx >= 96);
    chk(rx_pass == (m_rx >= 128), "R4 rx passive", rx_pass, m_rx >= 128);
    chk(tx_warn == (m_tx >= 97), "R5 tx warning", tx_warn, m_tx >= 97);
    chk(stat == st, "R6/R7 status bits", stat, st);
    chk(esum == (st != 0), "R8 summary flag", esum, st != 0);
    chk(irq == ((st != 0) && ie), "R9 interrupt", irq, (st != 0) && ie);
  endtask

  // one stimulus cycle: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input bit re, input bit ro, input logic [2:0] te, input bit to,
                      input bit bm, input logic [NB-1:0] ov, input logic [SW-1:0] cl);
    logic [SW-1:0] setv;
    rx_err = re; rx_ok = ro; {ta, tf, tb} = te; tok = to; bad = bm; ovr = ov; clr = cl;
    @(posedge clk);
    setv = '0;
    setv[0] = (m_rx >= 96);
    setv[1] = (m_tx > 96);
    setv[2] = (m_rx > 127);
    setv[3] = bm;
    for (int b = 0; b < NB; b++) setv[4+b] = ov[b];
    m_st = (m_st & ~cl) | setv;
    m_rx = clamp(m_rx + int'(re) - int'(ro));
    m_tx = clamp(m_tx + int'(te[0]) + int'(te[1]) + int'(te[2]) - int'(to));
    @(negedge clk);
    rx_err = 0; rx_ok = 0; {ta, tf, tb} = 3'b000; tok = 0; bad = 0; ovr = '0; clr = '0;
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rx_err = 0; rx_ok = 0; ta = 0; tf = 0; tb = 0; tok = 0; bad = 0; ovr = '0; clr = '0; ie = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all();  // reset state: everything zero

    // R1, R3, R4: count receive errors up past saturation
    for (int i = 0; i < 260; i++) step(1, 0, 3'b000, 0, 0, '0, '0);
    // R7: clear while the level conditions persist, set wins
    step(0, 0, 3'b000, 0, 0, '0, '1);
    // R1: simultaneous error and success leave the count alone
    for (int i = 0; i < 4; i++) step(1, 1, 3'b000, 0, 0, '0, '0);
    // R1, R3, R4: count back down below zero
    for (int i = 0; i < 260; i++) step(0, 1, 3'b000, 0, 0, '0, '0);
    step(0, 0, 3'b000, 0, 0, '0, '1);
    step(0, 0, 3'b000, 0, 0, '0, '0);

    // R8: a few transmit errors alone raise no status bit
    for (int i = 0; i < 8; i++) step(0, 0, 3'(i), 0, 0, '0, '0);
    // R2, R5: all error-class combinations, with occasional success
    for (int i = 0; i < 300; i++) step(0, 0, 3'(i % 8), (i % 5) == 0, 0, '0, '0);
    // R5 boundary: walk down through 97 and 96
    for (int i = 0; i < 300; i++) step(0, 0, 3'b000, 1, 0, '0, '0);
    step(0, 0, 3'b000, 0, 0, '0, '1);
    // R5: build up to exactly 96, then one more
    for (int i = 0; i < 32; i++) step(0, 0, 3'b111, 0, 0, '0, '0);
    step(0, 0, 3'b000, 0, 0, '0, '0);
    step(0, 0, 3'b001, 0, 0, '0, '0);
    step(0, 0, 3'b000, 0, 0, '0, '0);
    for (int i = 0; i < 120; i++) step(0, 0, 3'b000, 1, 0, '0, '0);
    step(0, 0, 3'b000, 0, 0, '0, '1);

    // R6, R7: event bits, clear in the same cycle loses
    step(0, 0, 3'b000, 0, 1, '0, 6'b001000);
    step(0, 0, 3'b000, 0, 0, '0, 6'b001000);
    for (int b = 0; b < NB; b++) begin
      step(0, 0, 3'b000, 0, 0, NB'(1 << b), '0);
      step(0, 0, 3'b000, 0, 0, '0, '0);
    end
    // R9: enable gates the request
    ie = 0;
    step(0, 0, 3'b000, 0, 0, '0, '0);
    ie = 1;
    step(0, 0, 3'b000, 0, 0, '0, '0);
    // R7: clear one bit at a time
    for (int b = 0; b < SW; b++) step(0, 0, 3'b000, 0, 0, '0, SW'(1 << b));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule